// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block watches the instruction sitting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It compares the two source register fields of that instruction against the destination of every younger-to-older producer in execute, memory and writeback. From that comparison it chooses where each ALU operand comes from, and decides whether fetch and decode must hold while execute receives a bubble. A redirect from a taken branch or jump squashes the instructions in fetch and decode.

An elaboration-time switch picks one of two flavours. With forwarding on, results are steered straight from the execute, memory or writeback stage into the operands. Only a load in execute whose data is needed by decode causes a hold. With forwarding off, every operand comes from the register file, and decode holds while any valid writer of a needed source is still in execute, memory or writeback. The register file is taken to have no write-through, so a writer in writeback still blocks.

The block holds no state. Its hazard classification is an enumerated operand source (register file, execute, memory, writeback) chosen per operand by a priority case.

Top module: `hzd_unit`

## Requirements
- R1: The first source register is taken from instruction bits [26:22] and the second from bits [21:17]; bits [31:27] (the destination field) and bits [16:0] never create a match.
- R2: With forwarding on, each operand select uses the encoding 2'b00 register file, 2'b01 execute, 2'b10 memory, 2'b11 writeback, and when several stages match it picks execute over memory over writeback.
- R3: A stage is a match only when its valid flag and its register write-enable are both high and its destination equals the source.
- R4: Source register 0 never matches, so it never forwards and never holds the pipeline.
- R5: With forwarding on, a load in execute whose destination matches a used source raises the fetch/decode hold and the execute bubble; a non-load match in any stage, or a load in memory, causes no hold.
- R6: With forwarding off, both operand selects stay 2'b00 and the hold is raised whenever any matching stage among execute, memory and writeback feeds a used source.
- R7: A source whose used flag is low never causes a hold.
- R8: Whenever the hold is high, the execute bubble is also high.
- R9: A taken branch or jump raises both kill outputs and the execute bubble and forces the hold low, even when a hazard is present.
- R10: With no match and no redirect, the hold, the bubble, both kills and both selects are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_inst | input | 32 | Instruction word in decode |
| dec_rs1_used | input | 1 | Decode reads its first source |
| dec_rs2_used | input | 1 | Decode reads its second source |
| ex_valid | input | 1 | Execute holds a real instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_rd | input | 5 | Execute destination register |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_wen | input | 1 | Memory stage instruction writes a register |
| mem_rd | input | 5 | Memory stage destination register |
| wb_valid | input | 1 | Writeback holds a real instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_rd | input | 5 | Writeback destination register |
| br_taken | input | 1 | Branch or jump resolved taken |
| stall_fd | output | 1 | Hold fetch and decode |
| ex_bubble | output | 1 | Inject a NOP into execute |
| kill_f | output | 1 | Squash the fetch-stage instruction |
| kill_d | output | 1 | Squash the decode-stage instruction |
| op1_sel | output | 2 | First operand source select |
| op2_sel | output | 2 | Second operand source select |

## Verification
Two copies run side by side under the same stimulus, one with forwarding and one interlocked, so every pattern shows how the two flavours differ. A single producer per stage tells the select encodings apart. Stacked producers with the same destination expose the priority order. Producers that are invalid, not writing, writing register 0, or matching only the destination field show that false matches are rejected. Load-use cases with the source used and unused, a load in memory, and a redirect on top of a load-use hazard separate the hold, bubble and kill paths.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    localparam int NUM_STG = 3;
    localparam int STG_EX  = 0;
    localparam int STG_MEM = 1;
    localparam int STG_WB  = 2;
    localparam int NUM_OPS = 2;

    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_EX  = 2'b01,
        SRC_MEM = 2'b10,
        SRC_WB  = 2'b11
    } fwd_src_e;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match
    import hzd_pkg::*;
#(
    parameter int RA_W = 5
) (
    input  logic [RA_W-1:0]               src,
    input  logic [NUM_STG-1:0][RA_W-1:0]  stg_rd,
    input  logic [NUM_STG-1:0]            stg_valid,
    input  logic [NUM_STG-1:0]            stg_wen,
    output logic [NUM_STG-1:0]            hit
);
    logic src_nonzero;
    assign src_nonzero = |src;

    for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
        assign hit[s] = src_nonzero && stg_valid[s] && stg_wen[s] && (stg_rd[s] == src);
    end
endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
    import hzd_pkg::*;
#(
    parameter bit FULL_BYPASS = 1'b1
) (
    input  logic [NUM_STG-1:0] hit,
    output fwd_src_e           sel
);
    if (FULL_BYPASS) begin : g_fwd
        always_comb begin
            priority casez (hit)
                3'b??1:  sel = SRC_EX;
                3'b?10:  sel = SRC_MEM;
                3'b100:  sel = SRC_WB;
                default: sel = SRC_RF;
            endcase
        end
    end else begin : g_lock
        logic unused_hit;
        assign unused_hit = ^hit;
        assign sel = SRC_RF;
    end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl
    import hzd_pkg::*;
#(
    parameter bit FULL_BYPASS = 1'b1
) (
    input  logic [NUM_OPS-1:0][NUM_STG-1:0] hit,
    input  logic [NUM_OPS-1:0]              used,
    input  logic                            ex_is_load,
    input  logic                            br_taken,
    output logic                            stall_fd,
    output logic                            ex_bubble,
    output logic                            kill_f,
    output logic                            kill_d
);
    logic [NUM_OPS-1:0] op_blocks;

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        if (FULL_BYPASS) begin : g_fwd
            assign op_blocks[o] = used[o] && hit[o][STG_EX] && ex_is_load;
        end else begin : g_lock
            assign op_blocks[o] = used[o] && (|hit[o]);
        end
    end

    logic need_hold;
    assign need_hold = |op_blocks;

    always_comb begin
        stall_fd  = need_hold && !br_taken;
        ex_bubble = need_hold || br_taken;
        kill_f    = br_taken;
        kill_d    = br_taken;
    end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int INST_W      = 32,
    parameter int RA_W        = 5,
    parameter int RS1_LSB     = 22,
    parameter int RS2_LSB     = 17,
    parameter bit FULL_BYPASS = 1'b1
) (
    input  logic [INST_W-1:0] dec_inst,
    input  logic              dec_rs1_used,
    input  logic              dec_rs2_used,
    input  logic              ex_valid,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [RA_W-1:0]   ex_rd,
    input  logic              mem_valid,
    input  logic              mem_wen,
    input  logic [RA_W-1:0]   mem_rd,
    input  logic              wb_valid,
    input  logic              wb_wen,
    input  logic [RA_W-1:0]   wb_rd,
    input  logic              br_taken,
    output logic              stall_fd,
    output logic              ex_bubble,
    output logic              kill_f,
    output logic              kill_d,
    output logic [1:0]        op1_sel,
    output logic [1:0]        op2_sel
);
    logic unused_inst;
    assign unused_inst = ^dec_inst;

    logic [NUM_OPS-1:0][RA_W-1:0]    src;
    logic [NUM_OPS-1:0]              used;
    logic [NUM_STG-1:0][RA_W-1:0]    stg_rd;
    logic [NUM_STG-1:0]              stg_valid;
    logic [NUM_STG-1:0]              stg_wen;
    logic [NUM_OPS-1:0][NUM_STG-1:0] hit;
    fwd_src_e                        sel [NUM_OPS];

    assign src[0]  = dec_inst[RS1_LSB +: RA_W];
    assign src[1]  = dec_inst[RS2_LSB +: RA_W];
    assign used    = {dec_rs2_used, dec_rs1_used};

    assign stg_rd[STG_EX]     = ex_rd;
    assign stg_rd[STG_MEM]    = mem_rd;
    assign stg_rd[STG_WB]     = wb_rd;
    assign stg_valid[STG_EX]  = ex_valid;
    assign stg_valid[STG_MEM] = mem_valid;
    assign stg_valid[STG_WB]  = wb_valid;
    assign stg_wen[STG_EX]    = ex_wen;
    assign stg_wen[STG_MEM]   = mem_wen;
    assign stg_wen[STG_WB]    = wb_wen;

    for (genvar o = 0; o < NUM_OPS; o++) begin : g_op
        hzd_src_match #(.RA_W(RA_W)) u_match (
            .src       (src[o]),
            .stg_rd    (stg_rd),
            .stg_valid (stg_valid),
            .stg_wen   (stg_wen),
            .hit       (hit[o])
        );
        hzd_fwd_sel #(.FULL_BYPASS(FULL_BYPASS)) u_sel (
            .hit (hit[o]),
            .sel (sel[o])
        );
    end

    assign op1_sel = sel[0];
    assign op2_sel = sel[1];

    hzd_stall_ctl #(.FULL_BYPASS(FULL_BYPASS)) u_ctl (
        .hit        (hit),
        .used       (used),
        .ex_is_load (ex_is_load),
        .br_taken   (br_taken),
        .stall_fd   (stall_fd),
        .ex_bubble  (ex_bubble),
        .kill_f     (kill_f),
        .kill_d     (kill_d)
    );
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk #(
    parameter int INST_W      = 32,
    parameter int RA_W        = 5,
    parameter int RS1_LSB     = 22,
    parameter int RS2_LSB     = 17,
    parameter bit FULL_BYPASS = 1'b1
) (
    input logic [INST_W-1:0] dec_inst,
    input logic              dec_rs1_used,
    input logic              dec_rs2_used,
    input logic              ex_valid,
    input logic              ex_wen,
    input logic              ex_is_load,
    input logic [RA_W-1:0]   ex_rd,
    input logic              br_taken,
    input logic              stall_fd,
    input logic              ex_bubble,
    input logic              kill_f,
    input logic              kill_d,
    input logic [1:0]        op1_sel,
    input logic [1:0]        op2_sel
);
    logic [RA_W-1:0] a1, a2;
    logic            ld_use;
    assign a1 = dec_inst[RS1_LSB +: RA_W];
    assign a2 = dec_inst[RS2_LSB +: RA_W];
    assign ld_use = ex_valid && ex_wen && ex_is_load &&
                    ((dec_rs1_used && a1 != '0 && a1 == ex_rd) ||
                     (dec_rs2_used && a2 != '0 && a2 == ex_rd));

    always @* begin
        // R8
        if (stall_fd) begin
            hold_bubble_chk: assert (ex_bubble);
        end
        // R9
        if (br_taken) begin
            redirect_kill_chk: assert (kill_f && kill_d && ex_bubble && !stall_fd);
        end
        // R4
        if (a1 == '0) begin
            zero_src1_chk: assert (op1_sel == 2'b00);
        end
        // R4
        if (a2 == '0) begin
            zero_src2_chk: assert (op2_sel == 2'b00);
        end
        // R6
        if (!FULL_BYPASS) begin
            lock_nofwd_chk: assert (op1_sel == 2'b00 && op2_sel == 2'b00);
        end
        // R5
        if (ld_use && !br_taken) begin
            load_use_chk: assert (stall_fd);
        end
    end
endmodule

bind hzd_unit hzd_unit_chk #(
    .INST_W(INST_W), .RA_W(RA_W), .RS1_LSB(RS1_LSB),
    .RS2_LSB(RS2_LSB), .FULL_BYPASS(FULL_BYPASS)
) chk_i (
    .dec_inst(dec_inst), .dec_rs1_used(dec_rs1_used), .dec_rs2_used(dec_rs2_used),
    .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_rd(ex_rd),
    .br_taken(br_taken), .stall_fd(stall_fd), .ex_bubble(ex_bubble),
    .kill_f(kill_f), .kill_d(kill_d), .op1_sel(op1_sel), .op2_sel(op2_sel)
);

// File: tb/hzd_unit_tb.sv
`timescale 1ns/1ps
module hzd_unit_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] dec_inst;
    logic dec_rs1_used, dec_rs2_used;
    logic ex_valid, ex_wen, ex_is_load;
    logic [4:0] ex_rd, mem_rd, wb_rd;
    logic mem_valid, mem_wen, wb_valid, wb_wen, br_taken;

    logic f_stall, f_bub, f_kf, f_kd;
    logic [1:0] f_s1, f_s2;
    logic l_stall, l_bub, l_kf, l_kd;
    logic [1:0] l_s1, l_s2;

    hzd_unit #(.FULL_BYPASS(1'b1)) dut_i (
        .dec_inst(dec_inst), .dec_rs1_used(dec_rs1_used), .dec_rs2_used(dec_rs2_used),
        .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_rd(ex_rd),
        .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd),
        .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd), .br_taken(br_taken),
        .stall_fd(f_stall), .ex_bubble(f_bub), .kill_f(f_kf), .kill_d(f_kd),
        .op1_sel(f_s1), .op2_sel(f_s2)
    );

    hzd_unit #(.FULL_BYPASS(1'b0)) dut_lock_i (
        .dec_inst(dec_inst), .dec_rs1_used(dec_rs1_used), .dec_rs2_used(dec_rs2_used),
        .ex_valid(ex_valid), .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_rd(ex_rd),
        .mem_valid(mem_valid), .mem_wen(mem_wen), .mem_rd(mem_rd),
        .wb_valid(wb_valid), .wb_wen(wb_wen), .wb_rd(wb_rd), .br_taken(br_taken),
        .stall_fd(l_stall), .ex_bubble(l_bub), .kill_f(l_kf), .kill_d(l_kd),
        .op1_sel(l_s1), .op2_sel(l_s2)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_inst(input logic [4:0] rd, input logic [4:0] r1, input logic [4:0] r2);
        return {rd, r1, r2, 17'h1A5C3};
    endfunction

    task automatic idle();
        dec_inst = mk_inst(5'd0, 5'd0, 5'd0);
        dec_rs1_used = 1'b1; dec_rs2_used = 1'b1;
        ex_valid = 0; ex_wen = 0; ex_is_load = 0; ex_rd = 0;
        mem_valid = 0; mem_wen = 0; mem_rd = 0;
        wb_valid = 0; wb_wen = 0; wb_rd = 0;
        br_taken = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_idle();
        idle();
        dec_inst = mk_inst(5'd7, 5'd3, 5'd4);
        settle();
        chk("R10", "fwd stall", f_stall, 0);
        chk("R10", "fwd bubble", f_bub, 0);
        chk("R10", "fwd kill", {f_kf, f_kd}, 0);
        chk("R10", "fwd sels", f_s1 | f_s2, 0);
        chk("R10", "lock stall", l_stall, 0);
    endtask

    task automatic t_single();
        idle();
        dec_inst = mk_inst(5'd0, 5'd5, 5'd6);
        ex_valid = 1; ex_wen = 1; ex_rd = 5;
        settle();
        chk("R2", "ex op1 sel", f_s1, 2'b01);
        chk("R5", "alu in ex no stall", f_stall, 0);
        chk("R6", "lock ex stall", l_stall, 1);
        chk("R6", "lock sel", l_s1, 2'b00);
        chk("R8", "lock bubble", l_bub, 1);
        idle();
        dec_inst = mk_inst(5'd0, 5'd5, 5'd6);
        mem_valid = 1; mem_wen = 1; mem_rd = 6;
        settle();
        chk("R2", "mem op2 sel", f_s2, 2'b10);
        chk("R2", "op1 untouched", f_s1, 2'b00);
        chk("R6", "lock mem stall", l_stall, 1);
        idle();
        dec_inst = mk_inst(5'd0, 5'd9, 5'd6);
        wb_valid = 1; wb_wen = 1; wb_rd = 9;
        settle();
        chk("R2", "wb op1 sel", f_s1, 2'b11);
        chk("R6", "lock wb stall", l_stall, 1);
    endtask

    task automatic t_priority();
        idle();
        dec_inst = mk_inst(5'd0, 5'd12, 5'd12);
        ex_valid = 1; ex_wen = 1; ex_rd = 12;
        mem_valid = 1; mem_wen = 1; mem_rd = 12;
        wb_valid = 1; wb_wen = 1; wb_rd = 12;
        settle();
        chk("R2", "ex over mem/wb op1", f_s1, 2'b01);
        chk("R2", "ex over mem/wb op2", f_s2, 2'b01);
        ex_valid = 0;
        settle();
        chk("R2", "mem over wb", f_s1, 2'b10);
    endtask

    task automatic t_qualify();
        idle();
        dec_inst = mk_inst(5'd0, 5'd8, 5'd8);
        ex_valid = 0; ex_wen = 1; ex_rd = 8;
        mem_valid = 1; mem_wen = 0; mem_rd = 8;
        settle();
        chk("R3", "invalid/nowrite sel", f_s1, 2'b00);
        chk("R3", "invalid/nowrite lock", l_stall, 0);
        idle();
        dec_inst = mk_inst(5'd0, 5'd0, 5'd0);
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 0;
        wb_valid = 1; wb_wen = 1; wb_rd = 0;
        settle();
        chk("R4", "r0 sel", f_s1, 2'b00);
        chk("R4", "r0 load no stall", f_stall, 0);
        chk("R4", "r0 lock no stall", l_stall, 0);
        idle();
        dec_inst = mk_inst(5'd14, 5'd2, 5'd3);
        ex_valid = 1; ex_wen = 1; ex_rd = 14;
        mem_valid = 1; mem_wen = 1; mem_rd = 5'h1A;
        settle();
        chk("R1", "rd field no match", f_s1 | f_s2, 2'b00);
        chk("R1", "rd field no lock", l_stall, 0);
    endtask

    task automatic t_load();
        idle();
        dec_inst = mk_inst(5'd0, 5'd1, 5'd10);
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 10;
        settle();
        chk("R5", "load-use stall", f_stall, 1);
        chk("R5", "load-use bubble", f_bub, 1);
        dec_rs2_used = 0;
        settle();
        chk("R7", "unused src fwd", f_stall, 0);
        chk("R7", "unused src lock", l_stall, 0);
        idle();
        dec_inst = mk_inst(5'd0, 5'd1, 5'd10);
        mem_valid = 1; mem_wen = 1; mem_rd = 10;
        ex_is_load = 1;
        settle();
        chk("R5", "load in mem no stall", f_stall, 0);
        chk("R2", "load in mem sel", f_s2, 2'b10);
    endtask

    task automatic t_branch();
        idle();
        dec_inst = mk_inst(5'd0, 5'd11, 5'd0);
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 11;
        br_taken = 1;
        settle();
        chk("R9", "fwd kills", {f_kf, f_kd}, 2'b11);
        chk("R9", "fwd stall off", f_stall, 0);
        chk("R9", "fwd bubble", f_bub, 1);
        chk("R9", "lock kills", {l_kf, l_kd}, 2'b11);
        chk("R9", "lock stall off", l_stall, 0);
        idle();
        br_taken = 1;
        settle();
        chk("R9", "plain redirect bubble", f_bub, 1);
    endtask

    initial begin
        idle();
        repeat (2) @(negedge clk);
        t_idle();
        t_single();
        t_priority();
        t_qualify();
        t_load();
        t_branch();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule